// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave with Write-Cycle Busy Window

This block is the slave side of a two-wire serial memory holding 2048 bytes. A bus master reaches it through an open-drain pair: the block samples the clock line and the data line, and pulls the data line low through a single enable output whenever it answers. Each transfer opens with a selection byte. That byte carries a fixed device code, the three most significant memory address bits, and a direction flag. After it the master either writes one byte or reads one or more bytes.

An internal address counter always points one past the location most recently touched by a read or a write. Reads can therefore continue from wherever the last access stopped. To read from a chosen location, the master first loads the counter with a short write-mode preamble and then restarts the bus in read mode. A completed byte write starts a fixed-length internal write cycle. During that cycle the block ignores every START, so the master can repeat the selection byte until it is acknowledged.

Both bus lines pass through multi-stage synchronizers clocked by a system clock that is much faster than the bus clock. All protocol decisions are taken from the synchronized edges.

Top module: `twi_mem_slave`

## Requirements
- R1: The selection byte is received MSB first as code 1010, then address bits 10, 9, 8, then the direction bit (1 = read, 0 = write). A byte with any other code gets no acknowledge, and the block stays silent until the next START.
- R2: A selection byte with the correct code is acknowledged: the data line is pulled low for the whole of the ninth clock.
- R3: A byte write is a write-mode selection byte, then a low address byte, then one data byte, each acknowledged. The data is stored at address {bits 10..8 from the selection byte, low address byte} when the closing STOP arrives.
- R4: A STOP that ends a byte write starts an internal write cycle of WR_CYCLES system clocks. During it, no START is recognised and the data line is never pulled. After it, a write-mode selection byte is acknowledged again.
- R5: After an access to location n (a read or a write), a read-mode selection byte returns the byte at n+1, and the counter moves on.
- R6: A write-mode selection byte plus a low address byte, followed by a repeated START and a read-mode selection byte, returns the byte at the loaded address.
- R7: In a read, each master acknowledge after a data byte makes the block send the next location. The counter wraps from 2047 to 0.
- R8: After the master leaves a data byte unacknowledged, the block releases the data line and sends nothing more until the next START.
- R9: A STOP at any point returns the block to idle with the data line released, and a write whose data byte is cut short by a STOP stores nothing and starts no write cycle. The block changes its data-line drive only while the clock line is low.
- R10: After reset the data line is released, no write cycle is running, and a selection byte is acknowledged at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the bus clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin (wired level) |
| sda_pull_o | output | 1 | 1 = pull the data line low, 0 = release it |

## Verification
The hardest situation to reach from the pins is a START that arrives while the internal write cycle is still running. It occurs only between the closing STOP of a write and a fixed number of system clocks later. The bench therefore polls right after every write's STOP. It uses a write-cycle length shorter than one poll transaction, so the first poll must go unanswered and a later one must be acknowledged. Counter wrap-around is reached by placing data at the top and bottom of the array and streaming a sequential read across the boundary.

// File: rtl/twi_mem_pkg.sv
`timescale 1ns/1ps
// Shared types for the two-wire memory slave.
// Assumes: one package per block; nothing here holds state.
package twi_mem_pkg;

    // Byte-engine states of the protocol controller
    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for a START
        ST_RX,     // shifting in a byte from the master
        ST_ACK,    // holding our acknowledge through the ninth clock
        ST_TX,     // shifting a byte out to the master
        ST_MACK,   // watching the master's acknowledge
        ST_SKIP    // silent until START or STOP
    } twi_state_t;

    // Which byte of a write-direction transfer is being received
    typedef enum logic [1:0] {
        PH_SEL,    // selection byte
        PH_LOW,    // low address byte
        PH_DATA    // data byte
    } rx_phase_t;

    // Fixed device code in the top nibble of the selection byte
    localparam logic [3:0] SEL_CODE = 4'b1010;

endpackage

// File: rtl/twi_line_sync.sv
`timescale 1ns/1ps
// Synchronizes the bus clock and data lines into the system clock domain.
// Produces single-cycle strobes for clock rise/fall and for START/STOP.
// Assumes: the system clock is much faster than the bus clock, so that
// each bus level lasts several system clocks.
module twi_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic                   scl_q;
    logic                   sda_q;

    // Synchronizer chains; idle bus level is high
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
        end
    end

    assign scl_s = scl_pipe[SYNC_STAGES-1];
    assign sda_s = sda_pipe[SYNC_STAGES-1];

    // One-cycle history of the synchronized levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    // Edge strobes: data edges while the clock stays high are bus conditions
    always_comb begin
        scl_rise  = scl_s & ~scl_q;
        scl_fall  = ~scl_s & scl_q;
        start_det = scl_s & scl_q & sda_q & ~sda_s;
        stop_det  = scl_s & scl_q & ~sda_q & sda_s;
    end
endmodule

// File: rtl/twi_mem_array.sv
`timescale 1ns/1ps
// Byte-wide storage with one synchronous write port and one
// asynchronous read port.
// Assumes: contents are undefined until written; no reset on the array.
module twi_mem_array #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    // Store one byte when the write strobe is high
    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/twi_busy_timer.sv
`timescale 1ns/1ps
// Counts out the internal write cycle after a committed write.
// Assumes: a load during an active count restarts it from the full length.
module twi_busy_timer #(
    parameter int CYCLES = 300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic busy
);
    localparam int CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] remain;

    // Load on commit, then count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load) begin
            remain <= CNT_W'(CYCLES);
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign busy = (remain != '0);
endmodule

// File: rtl/twi_mem_slave.sv
`timescale 1ns/1ps
// Two-wire serial memory slave: selection byte decode, single-byte writes,
// current/random/sequential reads, and a busy window after each write
// during which START is not recognised.
// Assumes: ADDR_W is 11, so the selection byte carries address bits 10..8
// in its bits 3..1. Bus lines are open-drain and are seen here as wired
// levels.
module twi_mem_slave
    import twi_mem_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int WR_CYCLES   = 300,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_pull_o
);
    localparam int HI_W = ADDR_W - 8;

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic busy;

    twi_state_t        st;
    twi_state_t        after_ack;
    rx_phase_t         phase;
    logic [3:0]        bit_cnt;
    logic [7:0]        shreg;
    logic [HI_W-1:0]   hi_bits;
    logic [ADDR_W-1:0] ptr;
    logic [7:0]        wbyte;
    logic              wpend;
    logic              m_acked;
    logic              pull;
    logic [7:0]        rd_byte;
    logic              commit;
    logic              in_idle;

    twi_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    twi_mem_array #(.ADDR_W(ADDR_W), .DATA_W(8)) u_array (
        .clk   (clk),
        .we    (commit),
        .waddr (ptr),
        .wdata (wbyte),
        .raddr (ptr),
        .rdata (rd_byte)
    );

    twi_busy_timer #(.CYCLES(WR_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (commit),
        .busy  (busy)
    );

    // A pending write is committed by the STOP that closes it
    assign commit  = stop_det & wpend;
    assign in_idle = (st == ST_IDLE);

    // Protocol controller: bus conditions first, then the byte engine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            after_ack <= ST_IDLE;
            phase     <= PH_SEL;
            bit_cnt   <= '0;
            shreg     <= '0;
            hi_bits   <= '0;
            ptr       <= '0;
            wbyte     <= '0;
            wpend     <= 1'b0;
            m_acked   <= 1'b0;
            pull      <= 1'b0;
        end else if (stop_det) begin
            st    <= ST_IDLE;
            pull  <= 1'b0;
            wpend <= 1'b0;
            if (wpend) begin
                ptr <= ptr + 1'b1;
            end
        end else if (start_det) begin
            st      <= busy ? ST_IDLE : ST_RX;
            phase   <= PH_SEL;
            bit_cnt <= '0;
            pull    <= 1'b0;
            wpend   <= 1'b0;
        end else begin
            unique case (st)
                ST_RX: begin
                    if (scl_rise && bit_cnt != 4'd8) begin
                        shreg   <= {shreg[6:0], sda_s};
                        bit_cnt <= bit_cnt + 1'b1;
                    end else if (scl_fall && bit_cnt == 4'd8) begin
                        bit_cnt <= '0;
                        unique case (phase)
                            PH_SEL: begin
                                if (shreg[7:4] == SEL_CODE) begin
                                    hi_bits   <= shreg[HI_W:1];
                                    pull      <= 1'b1;
                                    st        <= ST_ACK;
                                    after_ack <= shreg[0] ? ST_TX : ST_RX;
                                    phase     <= PH_LOW;
                                end else begin
                                    st <= ST_SKIP;
                                end
                            end
                            PH_LOW: begin
                                ptr       <= {hi_bits, shreg};
                                pull      <= 1'b1;
                                st        <= ST_ACK;
                                after_ack <= ST_RX;
                                phase     <= PH_DATA;
                            end
                            default: begin
                                wbyte     <= shreg;
                                wpend     <= 1'b1;
                                pull      <= 1'b1;
                                st        <= ST_ACK;
                                after_ack <= ST_SKIP;
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        bit_cnt <= '0;
                        st      <= after_ack;
                        if (after_ack == ST_TX) begin
                            shreg <= rd_byte;
                            pull  <= ~rd_byte[7];
                            ptr   <= ptr + 1'b1;
                        end else begin
                            pull <= 1'b0;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (bit_cnt == 4'd7) begin
                            pull    <= 1'b0;
                            bit_cnt <= '0;
                            st      <= ST_MACK;
                        end else begin
                            shreg   <= {shreg[6:0], 1'b0};
                            pull    <= ~shreg[6];
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        m_acked <= ~sda_s;
                    end else if (scl_fall) begin
                        if (m_acked) begin
                            shreg <= rd_byte;
                            pull  <= ~rd_byte[7];
                            ptr   <= ptr + 1'b1;
                            st    <= ST_TX;
                        end else begin
                            st <= ST_SKIP;
                        end
                    end
                end
                default: begin
                    pull <= 1'b0;
                end
            endcase
        end
    end

    assign sda_pull_o = pull;
endmodule

// File: rtl/twi_mem_chk.sv
`timescale 1ns/1ps
// Protocol checker for the two-wire memory slave, attached by bind.
// Assumes: reset is synchronous and active low.
module twi_mem_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_s,
    input logic sda_pull_o,
    input logic stop_det,
    input logic busy,
    input logic in_idle
);
    // R4: the data line is never pulled while the write cycle runs
    a_r4_silent_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sda_pull_o)
        else $error("a_r4_silent_while_busy");

    // R4: a write cycle begins only right after a STOP
    a_r4_busy_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_det))
        else $error("a_r4_busy_after_stop");

    // R9: data-line drive moves only while the clock line is low
    a_r9_drive_with_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull_o) |-> !scl_s)
        else $error("a_r9_drive_with_scl_low");

    // R9: a STOP always lands in idle with the line released
    a_r9_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (in_idle && !sda_pull_o))
        else $error("a_r9_stop_to_idle");
endmodule

bind twi_mem_slave twi_mem_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_s      (scl_s),
    .sda_pull_o (sda_pull_o),
    .stop_det   (stop_det),
    .busy       (busy),
    .in_idle    (in_idle)
);

// File: tb/sim_twi_mem_slave.sv
`timescale 1ns/1ps
// Bench: bit-banged bus master sweeping writes and every read form.
module sim_twi_mem_slave;
    localparam int Q = 8;  // system clocks per quarter bus period

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_pull;
    logic sda_line;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    assign sda_line = sda_m & ~sda_pull;

    always #4 clk = ~clk;

    twi_mem_slave u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl),
        .sda_i      (sda_line),
        .sda_pull_o (sda_pull)
    );

    // Data pattern written to each address
    function automatic logic [7:0] pat(int a);
        return 8'((a * 37 + (a >> 8) * 11 + 5) & 255);
    endfunction

    task automatic check_eq(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq();
        scl = 1'b1;   wq();
        sda_m = 1'b0; wq();
        scl = 1'b0;   wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq();
        scl = 1'b1;   wq();
        sda_m = 1'b1; wq();
    endtask

    task automatic send_bits(logic [7:0] b, int n);
        for (int i = 0; i < n; i++) begin
            sda_m = b[7 - i]; wq();
            scl = 1'b1; wq(); wq();
            scl = 1'b0; wq();
        end
    endtask

    task automatic send_byte(logic [7:0] b, output bit ack);
        send_bits(b, 8);
        sda_m = 1'b1; wq();
        scl = 1'b1; wq();
        ack = (sda_line == 1'b0);
        wq();
        scl = 1'b0; wq();
    endtask

    task automatic recv_byte(bit give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq();
            scl = 1'b1; wq();
            b[i] = sda_line;
            wq();
            scl = 1'b0;
        end
        wq();
        sda_m = give_ack ? 1'b0 : 1'b1; wq();
        scl = 1'b1; wq(); wq();
        scl = 1'b0; wq();
        sda_m = 1'b1;
    endtask

    function automatic logic [7:0] sel(logic [10:0] a, bit rd);
        return {4'b1010, a[10:8], rd};
    endfunction

    // R3 write then R4 polling until acknowledged
    task automatic write_byte(logic [10:0] a, logic [7:0] d);
        bit ack;
        int tries = 0;
        bit got = 1'b0;
        bus_start();
        send_byte(sel(a, 1'b0), ack); check_eq("R2 select ack", ack, 1);
        send_byte(a[7:0], ack);       check_eq("R3 address ack", ack, 1);
        send_byte(d, ack);            check_eq("R3 data ack", ack, 1);
        bus_stop();
        while (!got && tries < 20) begin
            bus_start();
            send_byte(sel(a, 1'b0), ack);
            bus_stop();
            tries++;
            got = ack;
        end
        check_eq("R4 first poll unanswered", int'(tries > 1), 1);
        check_eq("R4 poll answered after write cycle", got, 1);
    endtask

    task automatic set_ptr(logic [10:0] a);
        bit ack;
        bus_start();
        send_byte(sel(a, 1'b0), ack); check_eq("R6 select ack", ack, 1);
        send_byte(a[7:0], ack);       check_eq("R6 address ack", ack, 1);
    endtask

    task automatic read_random(logic [10:0] a, string req);
        bit ack;
        logic [7:0] d;
        set_ptr(a);
        bus_start();
        send_byte(sel(a, 1'b1), ack); check_eq("R2 read select ack", ack, 1);
        recv_byte(1'b0, d);
        bus_stop();
        check_eq(req, d, pat(a));
    endtask

    task automatic read_current(int exp_a, string req);
        bit ack;
        logic [7:0] d;
        bus_start();
        send_byte(8'b1010_111_1, ack); check_eq("R2 read select ack", ack, 1);
        recv_byte(1'b0, d);
        bus_stop();
        check_eq(req, d, pat(exp_a));
    endtask

    initial begin
        bit ack;
        logic [7:0] d;
        logic [10:0] spread [12];
        logic [10:0] blk [8];
        for (int k = 0; k < 12; k++) spread[k] = 11'(150 + k * 171);
        for (int k = 0; k < 8; k++)  blk[k] = 11'(2044 + k);

        // R10: reset state
        repeat (5) @(negedge clk);
        check_eq("R10 line released in reset", sda_pull, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check_eq("R10 line released after reset", sda_pull, 0);
        bus_start();
        send_byte(8'hA0, ack);
        bus_stop();
        check_eq("R10 immediate select ack", ack, 1);

        // R1: wrong device codes are not acknowledged
        bus_start(); send_byte(8'h50, ack); bus_stop();
        check_eq("R1 code 0101 no ack", ack, 0);
        bus_start(); send_byte(8'hE1, ack); bus_stop();
        check_eq("R1 code 1110 no ack", ack, 0);
        bus_start(); send_byte(8'hB0, ack); bus_stop();
        check_eq("R1 code 1011 no ack", ack, 0);

        // R3/R4: writes across the whole address range
        for (int k = 0; k < 8; k++)  write_byte(blk[k], pat(blk[k]));
        for (int k = 0; k < 12; k++) write_byte(spread[k], pat(spread[k]));

        // R6: random reads of every written location
        for (int k = 0; k < 12; k++) read_random(spread[k], "R6 random read spread");
        for (int k = 0; k < 8; k++)  read_random(blk[k], "R6 random read block");

        // R5: current reads step on from the last access, with wrap
        read_random(11'd2044, "R6 random read 2044");
        read_current(2045, "R5 current after read");
        read_current(2046, "R5 current step");
        read_current(2047, "R5 current step to top");
        read_current(0, "R7 current wraps to 0");
        write_byte(11'd1, pat(1));
        read_current(2, "R5 current after write");

        // R7: sequential read across the top of the array
        set_ptr(11'd2045);
        bus_start();
        send_byte(sel(11'd2045, 1'b1), ack); check_eq("R2 read select ack", ack, 1);
        for (int i = 0; i < 5; i++) begin
            recv_byte(i < 4, d);
            check_eq("R7 sequential wrap byte", d, pat((2045 + i) % 2048));
        end
        bus_stop();
        // R7: current-address sequential read continues from 2
        bus_start();
        send_byte(8'hA1, ack); check_eq("R2 read select ack", ack, 1);
        recv_byte(1'b1, d); check_eq("R7 current sequential 1st", d, pat(2));
        recv_byte(1'b0, d); check_eq("R7 current sequential 2nd", d, pat(3));
        bus_stop();

        // R8: after a NACK the block stays silent
        set_ptr(11'd2046);
        bus_start();
        send_byte(sel(11'd2046, 1'b1), ack);
        recv_byte(1'b0, d); check_eq("R6 read 2046", d, pat(2046));
        recv_byte(1'b0, d); check_eq("R8 silent after nack", d, 8'hFF);
        bus_stop();
        read_current(2047, "R8 counter untouched by extra clocks");

        // R9: STOP inside a selection byte returns to idle
        bus_start(); send_bits(8'hA0, 4); bus_stop();
        check_eq("R9 released after stop", sda_pull, 0);
        read_current(0, "R9 counter kept over aborted select");

        // R9: STOP inside a data byte stores nothing and starts no write cycle
        set_ptr(11'd2044);
        send_bits(8'h5A, 5);
        bus_stop();
        bus_start(); send_byte(8'hA0, ack); bus_stop();
        check_eq("R9 no write cycle after aborted data", ack, 1);
        read_random(11'd2044, "R9 aborted data not stored");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog R10 actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule